// File: doc/BRIEF.md
# Indirect-Indexed Codec Control Register Bank

This block is the control register file of an audio codec, reached over a simple 32-bit slave bus. The bus carries a 4-bit word index, so the interconnect passes the byte offset within the 64-byte window shifted right by two. The bank holds sixteen 32-bit registers that are addressed directly. It also holds thirty-two 8-bit registers that are reached indirectly. Direct register 0 holds the pointer, and its low five bits pick the indirect entry. Direct register 1 is the data window onto that entry.

Some indirect entries follow special rules. Entry 3 can be written but always reads as zero. Entries 11 and 25 cannot be written. Entry 12 keeps a fixed codec version code and lets software change only bit 6. Entry 25 holds a fixed chip version code. Direct register 2 ignores writes. Direct register 4 keeps only its low seven bits. A write to register 4 with bit 0 set performs a full soft reset of the bank.

A small two-state access machine sequences reads. In state `ST_IDLE` no read response is pending. A read strobe causes the transition `IDLE->RESP`, and the machine enters `ST_RESP` for one cycle, during which `rvalid` is high. It returns to `ST_IDLE` through `RESP->IDLE` when no new read arrives. It stays in `ST_RESP` through `RESP->RESP` when reads arrive back to back. The interrupt output is held inactive.

Top module: `codec_regbank`

## Requirements
- R1: After reset (synchronous, active-high `rst`), every direct register reads 0, indirect entry 12 reads 0x8A, indirect entry 25 reads 0xA0, all other indirect entries read 0, and `rvalid` is low.
- R2: `rdata` and `rvalid` are registered. A read strobe accepted at one clock edge gives `rvalid` high with valid data after that edge, and `rvalid` is low in any cycle that did not follow a read strobe.
- R3: A write to any direct register other than 1, 2 and 4 stores all 32 bits, and a later read returns them.
- R4: The indirect pointer is bits [4:0] of direct register 0. A read of direct register 1 returns the selected 8-bit entry in `rdata[7:0]`, with the upper bits zero. A write to direct register 1 stores `wdata[7:0]` into the selected entry.
- R5: Indirect entry 3 reads as zero at all times, even after a write to it.
- R6: Writes through the window to indirect entries 11 and 25 are ignored.
- R7: A window write to indirect entry 12 stores (`wdata[7:0]` AND 0x40) OR 0x8A.
- R8: Writes to direct register 2 are ignored, and it reads 0.
- R9: A write to direct register 4 stores `wdata` AND 0x7F.
- R10: A write to direct register 4 with `wdata[0]` = 1 returns every register to its R1 value, and then stores `wdata` AND 0x7F in direct register 4.
- R11: `irq` is low at all times.
- R12: When a read strobe and a write strobe arrive in the same cycle, the read returns the value held before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 4 | Word index of the direct register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while `rvalid` is high |
| rvalid | output | 1 | Read response valid, one cycle after `rd_en` |
| irq | output | 1 | Interrupt, held low |

## Verification
Directed sequences first sweep every direct and indirect location after reset. They then exercise each special indirect entry with all-ones and all-zeros data, which separates a masked store from a plain store and from an ignored write. A long run of random reads and writes follows, with the random pointer landing on every entry. Rare random soft resets appear in that run, so restored defaults get checked against state that had drifted far from reset. A simultaneous read and write to the same register shows whether the read path samples the old or the new value.

// File: rtl/cbank_pkg.sv
package cbank_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ENTRY_W  = 8;
    localparam int unsigned N_DIRECT = 16;
    localparam int unsigned N_ENTRY  = 32;

    // direct register roles (behaviour depends on these positions)
    localparam int unsigned REG_PTR  = 0;
    localparam int unsigned REG_WIN  = 1;
    localparam int unsigned REG_LOCK = 2;
    localparam int unsigned REG_CTL  = 4;

    // indirect entries with special rules
    localparam int unsigned ENT_WONLY = 3;
    localparam int unsigned ENT_RO    = 11;
    localparam int unsigned ENT_CVER  = 12;
    localparam int unsigned ENT_IVER  = 25;

    localparam logic [7:0] CODEC_VER = 8'h8A;
    localparam logic [7:0] CHIP_VER  = 8'hA0;
    localparam logic [7:0] CVER_KEEP = 8'h40;
    localparam logic [31:0] CTL_MASK = 32'h0000_007F;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } acc_state_t;

    function automatic logic [7:0] entry_init(input int unsigned n);
        if (n == ENT_CVER)      return CODEC_VER;
        else if (n == ENT_IVER) return CHIP_VER;
        else                    return 8'h00;
    endfunction

endpackage

// File: rtl/cbank_fsm.sv
module cbank_fsm
    import cbank_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_en,
    output logic resp_valid,
    output logic capture
);

    acc_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_en) state_d = ST_RESP;   // IDLE->RESP
            ST_RESP: if (!rd_en) state_d = ST_IDLE;  // RESP->IDLE, else RESP->RESP
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        resp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: resp_valid = 1'b0;
            ST_RESP: resp_valid = 1'b1;
            default: resp_valid = 1'b0;
        endcase
    end

    assign capture = rd_en;

    AST_RESP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> resp_valid) else $error("resp missing"); // R2
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !resp_valid) else $error("spurious resp"); // R2

endmodule

// File: rtl/cbank_direct.sv
module cbank_direct
    import cbank_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned ND = N_DIRECT,
    localparam int unsigned AW = $clog2(ND)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  soft_rst,
    input  logic                  wr_en,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    output logic [ND-1:0][DW-1:0] dregs
);

    for (genvar g = 0; g < ND; g++) begin : g_reg
        if (g == REG_WIN || g == REG_LOCK) begin : g_const
            // window has no storage here; lock register ignores writes
            assign dregs[g] = '0;
        end else if (g == REG_CTL) begin : g_ctl
            always_ff @(posedge clk) begin
                if (rst)
                    dregs[g] <= '0;
                else if (wr_en && addr == AW'(g))
                    dregs[g] <= wdata & DW'(CTL_MASK);
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst || soft_rst)
                    dregs[g] <= '0;
                else if (wr_en && addr == AW'(g))
                    dregs[g] <= wdata;
            end
        end
    end

    AST_LOCK_ZERO: assert property (@(posedge clk) disable iff (rst)
        dregs[REG_LOCK] == '0) else $error("lock reg changed"); // R8
    AST_CTL_MASKED: assert property (@(posedge clk) disable iff (rst)
        (dregs[REG_CTL] & ~DW'(CTL_MASK)) == '0) else $error("ctl unmasked"); // R9
    AST_SOFT_CLEARS_PTR: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> dregs[REG_PTR] == '0) else $error("ptr kept"); // R10

endmodule

// File: rtl/cbank_indirect.sv
module cbank_indirect
    import cbank_pkg::*;
#(
    parameter int unsigned IW = ENTRY_W,
    parameter int unsigned NI = N_ENTRY,
    localparam int unsigned XW = $clog2(NI)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [XW-1:0] idx,
    input  logic [IW-1:0] wdata,
    output logic [IW-1:0] rd_data
);

    logic [NI-1:0][IW-1:0] ent;

    for (genvar g = 0; g < NI; g++) begin : g_ent
        if (g == ENT_RO || g == ENT_IVER) begin : g_ro
            always_ff @(posedge clk) begin
                if (clr) ent[g] <= IW'(entry_init(g));
            end
        end else if (g == ENT_CVER) begin : g_ver
            always_ff @(posedge clk) begin
                if (clr)
                    ent[g] <= IW'(CODEC_VER);
                else if (wr_en && idx == XW'(g))
                    ent[g] <= (wdata & IW'(CVER_KEEP)) | IW'(CODEC_VER);
            end
        end else begin : g_rw
            always_ff @(posedge clk) begin
                if (clr)
                    ent[g] <= IW'(entry_init(g));
                else if (wr_en && idx == XW'(g))
                    ent[g] <= wdata;
            end
        end
    end

    assign rd_data = (idx == XW'(ENT_WONLY)) ? '0 : ent[idx];

    AST_CODEC_VER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (ent[ENT_CVER] & ~IW'(CVER_KEEP)) == IW'(CODEC_VER)) else $error("cver"); // R7
    AST_CHIP_VER_FIXED: assert property (@(posedge clk) disable iff (rst)
        ent[ENT_IVER] == IW'(CHIP_VER)) else $error("iver"); // R6
    AST_RO_ENTRY_ZERO: assert property (@(posedge clk) disable iff (rst)
        ent[ENT_RO] == '0) else $error("ro entry"); // R6

endmodule

// File: rtl/codec_regbank.sv
module codec_regbank
    import cbank_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned IW = ENTRY_W,
    parameter int unsigned ND = N_DIRECT,
    parameter int unsigned NI = N_ENTRY,
    localparam int unsigned AW = $clog2(ND),
    localparam int unsigned XW = $clog2(NI)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          irq
);

    logic [ND-1:0][DW-1:0] dregs;
    logic [IW-1:0]         ent_rd;
    logic [XW-1:0]         ptr;
    logic                  win_sel, soft_rst, clr_all, capture;
    logic [DW-1:0]         rd_mux, rdata_q;

    assign win_sel  = (addr == AW'(REG_WIN));
    assign soft_rst = wr_en && (addr == AW'(REG_CTL)) && wdata[0];
    assign clr_all  = rst || soft_rst;
    assign ptr      = dregs[REG_PTR][XW-1:0];

    cbank_fsm i_fsm (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .resp_valid (rvalid),
        .capture    (capture)
    );

    cbank_direct #(.DW(DW), .ND(ND)) i_direct (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .wr_en    (wr_en && !win_sel),
        .addr     (addr),
        .wdata    (wdata),
        .dregs    (dregs)
    );

    cbank_indirect #(.IW(IW), .NI(NI)) i_indirect (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_all),
        .wr_en   (wr_en && win_sel),
        .idx     (ptr),
        .wdata   (wdata[IW-1:0]),
        .rd_data (ent_rd)
    );

    assign rd_mux = win_sel ? DW'(ent_rd) : dregs[addr];

    always_ff @(posedge clk) begin
        if (rst)          rdata_q <= '0;
        else if (capture) rdata_q <= rd_mux;
    end

    assign rdata = rdata_q;
    assign irq   = 1'b0;

    AST_WONLY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && win_sel && ptr == XW'(ENT_WONLY)) |=> rdata == '0)
        else $error("write-only entry leaked"); // R5
    AST_WIN_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && win_sel) |=> (rdata >> IW) == '0) else $error("window upper"); // R4

endmodule

// File: tb/test_codec_regbank.sv
module test_codec_regbank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] dm [16];
    logic [7:0]  im [32];

    always #2.5 clk = ~clk;

    codec_regbank i_codec_regbank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic void mdl_reset();
        for (int i = 0; i < 16; i++) dm[i] = '0;
        for (int i = 0; i < 32; i++) im[i] = '0;
        im[12] = 8'h8A;
        im[25] = 8'hA0;
    endfunction

    function automatic void mdl_write(input int w, input logic [31:0] v);
        int idx;
        idx = int'(dm[0][4:0]);
        case (w)
            1: begin
                if (idx == 11 || idx == 25) ;
                else if (idx == 12) im[12] = (v[7:0] & 8'h40) | 8'h8A;
                else im[idx] = v[7:0];
            end
            2: ;
            4: begin
                if (v[0]) mdl_reset();
                dm[4] = v & 32'h7F;
            end
            default: dm[w] = v;
        endcase
    endfunction

    function automatic logic [31:0] mdl_read(input int w);
        int idx;
        idx = int'(dm[0][4:0]);
        if (w == 1) return (idx == 3) ? 32'h0 : {24'h0, im[idx]};
        return dm[w];
    endfunction

    function automatic string tag_of(input int w);
        if (w == 1) return "R4";
        if (w == 2) return "R8";
        if (w == 4) return "R9";
        return "R3";
    endfunction

    task automatic do_write(input int w, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'(w); wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
        mdl_write(w, v);
    endtask

    task automatic do_read(input int w, input string req);
        logic [31:0] exp;
        exp = mdl_read(w);
        @(negedge clk);
        rd_en = 1'b1; addr = 4'(w);
        @(negedge clk);
        rd_en = 1'b0;
        check({req, " rvalid"}, {31'h0, rvalid}, 32'h1);
        check(req, rdata, exp);
    endtask

    task automatic read_entry(input int e, input string req);
        do_write(0, 32'(e));
        do_read(1, req);
    endtask

    initial begin
        void'($urandom(32'd1234));
        mdl_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rvalid idle", {31'h0, rvalid}, 32'h0);
        check("R11 irq", {31'h0, irq}, 32'h0);

        // R1: reset contents
        for (int w = 0; w < 16; w++) do_read(w, "R1 direct");
        for (int e = 0; e < 32; e++) read_entry(e, "R1 entry");

        // R2: rvalid drops after a single read
        @(negedge clk);
        check("R2 rvalid low", {31'h0, rvalid}, 32'h0);

        // R3: full-width store
        do_write(7, 32'hDEAD_BEEF);
        do_read(7, "R3");
        do_write(15, 32'hFFFF_FFFF);
        do_read(15, "R3");

        // R5: write-only entry
        do_write(0, 32'd3);
        do_write(1, 32'h55);
        do_read(1, "R5");
        do_write(0, 32'hFFFF_FFE3); // pointer bits above 4 ignored
        do_read(1, "R5 high ptr bits");

        // R6: read-only entries
        do_write(0, 32'd11); do_write(1, 32'hFF); do_read(1, "R6 e11");
        do_write(0, 32'd25); do_write(1, 32'h00); do_read(1, "R6 e25");

        // R7: version entry keeps code
        do_write(0, 32'd12); do_write(1, 32'hFF); do_read(1, "R7 ones");
        check("R7 value", mdl_read(1), 32'hCA);
        do_write(1, 32'h00); do_read(1, "R7 zeros");

        // R4: plain entry
        do_write(0, 32'd31); do_write(1, 32'h1A5); do_read(1, "R4");

        // R8
        do_write(2, 32'h1234_5678);
        do_read(2, "R8");

        // R9
        do_write(4, 32'hFFFF_FFFE);
        do_read(4, "R9");

        // R10: soft reset
        do_write(9, 32'hA5A5_0001);
        do_write(0, 32'd5); do_write(1, 32'h77);
        do_write(4, 32'hFFFF_FFFF);
        do_read(4, "R10 ctl");
        do_read(9, "R10 cleared");
        do_read(0, "R10 ptr");
        read_entry(5, "R10 entry");
        read_entry(12, "R10 cver");
        read_entry(25, "R10 iver");

        // R12: read and write in the same cycle
        do_write(5, 32'h1111_1111);
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; addr = 4'd5; wdata = 32'h2222_2222;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check("R12 old value", rdata, 32'h1111_1111);
        mdl_write(5, 32'h2222_2222);
        do_read(5, "R12 new value");

        // random mix
        for (int n = 0; n < 1500; n++) begin
            int w;
            logic [31:0] v;
            w = int'($urandom_range(0, 15));
            v = $urandom;
            if (w == 4 && $urandom_range(0, 7) != 0) v[0] = 1'b0;
            if ($urandom_range(0, 1) == 1) do_write(w, v);
            else do_read(w, tag_of(w));
            if (irq !== 1'b0) check("R11 irq", {31'h0, irq}, 32'h0);
        end

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule